// File: doc/BRIEF.md
# Word-Addressed SPI Memory Access Controller

This block sits between a multi-cycle 16-bit processor and its external storage. Every request carries a 16-bit word address, which the controller assigns to one of three regions: read-only serial NOR flash, a 256-word I/O register window, or serial SRAM. Flash and SRAM accesses become one full SPI master transaction on a shared clock, data-out and data-in bus, with a separate active-low select for each device. I/O accesses are passed straight to an external register block through a single-cycle strobe.

The processor holds `req`, `we`, `addr` and `wdata` steady until it sees a cycle with `req` high and `stall` low. That cycle completes the access, and for reads `rdata` is valid in it. I/O accesses complete in the cycle they are presented. A serial access keeps `stall` high for the whole transaction. The processor then drops `req`, or starts the next access once the controller is idle again.

Top module: `wordspi_memctl`

## Requirements
- R1: A request with an address from 0x0000 to 0x7EFF reads from the flash. Only `flash_cs_n` goes low, and the first byte shifted out is the read command 0x03.
- R2: A request with an address from 0x7F00 to 0x7FFF raises `io_stb` in the same cycle. `io_addr` is `addr[7:0]`, and `io_we` and `io_wdata` follow the request. `rdata` equals `io_rdata`, `stall` stays low and no chip select is asserted.
- R3: A request with an address from 0x8000 to 0xFFFF uses the SRAM with `sram_cs_n` low. Reads send command 0x03 and writes send command 0x02.
- R4: After the command, the 24-bit byte address is sent most significant bit first. Its value is the word address multiplied by two.
- R5: The data phase carries 16 bits, high byte first. On a write, `wdata[15]` is sent first. On a read, MOSI stays low, and the first data bit received on MISO becomes `rdata[15]`.
- R6: `sclk` idles low and runs at half the system clock in SPI mode 0. Each bit spends one cycle low, with MOSI already set, followed by one cycle high. MISO is sampled at the rising edge.
- R7: A serial access keeps `stall` high in the cycle the request is accepted and for the 96 cycles of the 48-bit frame. In the next cycle `stall` is low, both selects are high and `rdata` holds the read word.
- R8: A write to the flash region is dropped. `stall` is high for exactly one cycle, no select goes low and `sclk` stays low.
- R9: At most one chip select is low at a time. Both are high during reset and whenever no transaction is running.
- R10: The region edges decode exactly. 0x7EFF is flash, 0x7F00 and 0x7FFF are I/O, and 0x8000 is SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request from the processor |
| we | input | 1 | Write enable for the request |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data word |
| rdata | output | 16 | Read data word |
| stall | output | 1 | Processor must hold the request while high |
| io_stb | output | 1 | One-cycle strobe for an I/O window access |
| io_we | output | 1 | Write flag for the I/O access |
| io_addr | output | 8 | Register index inside the I/O window |
| io_wdata | output | 16 | Write data for the I/O access |
| io_rdata | input | 16 | Read data returned by the register block |
| flash_cs_n | output | 1 | Flash chip select, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |

## Verification
The assertions assume that the processor keeps `addr` and `we` stable for as long as `stall` is high. The flash-write check reads the region from `addr` in the accept cycle and expects it not to change afterwards. The bench drives every request this way. It changes inputs only after a completion cycle, drops `req` for at least one cycle between accesses, and presents each new request only while the controller is idle.

// File: rtl/wordspi_memctl.sv
module wordspi_memctl #(
  parameter logic [15:0] FLASH_LAST = 16'h7EFF,
  parameter logic [15:0] IO_LAST    = 16'h7FFF,
  parameter logic [7:0]  CMD_READ   = 8'h03,
  parameter logic [7:0]  CMD_WRITE  = 8'h02,
  parameter int          DATA_W     = 16,
  parameter int          BADDR_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [15:0]       addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              stall,
  output logic              io_stb,
  output logic              io_we,
  output logic [7:0]        io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              flash_cs_n,
  output logic              sram_cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int FRAME_W = 8 + BADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  typedef enum logic [1:0] {IDLE, SHIFT, ACK} state_t;

  state_t             st;
  logic [CNT_W-1:0]   bit_cnt;
  logic               ph;
  logic               to_flash;
  logic [FRAME_W-1:0] tx_sr;
  logic [DATA_W-1:0]  rx_sr;

  logic               in_flash, in_io, idle, busy, take;
  logic [BADDR_W-1:0] byte_addr;

  assign in_flash  = addr <= FLASH_LAST;
  assign in_io     = !in_flash && addr <= IO_LAST;
  assign idle      = st == IDLE;
  assign busy      = st == SHIFT;
  assign take      = req && idle && !in_io;
  assign byte_addr = {{(BADDR_W-17){1'b0}}, addr, 1'b0};

  assign io_stb   = req && idle && in_io;
  assign io_we    = we;
  assign io_addr  = addr[7:0];
  assign io_wdata = wdata;

  assign stall      = busy || take;
  assign rdata      = in_io ? io_rdata : rx_sr;
  assign sclk       = busy && ph;
  assign mosi       = busy && tx_sr[FRAME_W-1];
  assign flash_cs_n = !(busy && to_flash);
  assign sram_cs_n  = !(busy && !to_flash);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      bit_cnt  <= '0;
      ph       <= 1'b0;
      to_flash <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else begin
      case (st)
        IDLE: if (take) begin
          if (in_flash && we) begin
            st <= ACK;
          end else begin
            st       <= SHIFT;
            ph       <= 1'b0;
            bit_cnt  <= '0;
            to_flash <= in_flash;
            tx_sr    <= {we ? CMD_WRITE : CMD_READ, byte_addr,
                         we ? wdata : {DATA_W{1'b0}}};
          end
        end
        SHIFT: begin
          if (!ph) begin
            ph    <= 1'b1;
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
          end else begin
            ph    <= 1'b0;
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            if (bit_cnt == LAST_BIT) st <= ACK;
            else bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wordspi_memctl_chk.sv
module wordspi_memctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [15:0] addr,
  input logic        stall,
  input logic        io_stb,
  input logic        flash_cs_n,
  input logic        sram_cs_n,
  input logic        sclk
);
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_cs_n && !sram_cs_n));

  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_cs_n && sram_cs_n) |-> !sclk);

  a_r6_sclk_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  a_r2_io_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb |-> (!stall && flash_cs_n && sram_cs_n));

  a_r8_flash_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr <= 16'h7EFF && stall && flash_cs_n && sram_cs_n)
      |=> (!stall && flash_cs_n && sram_cs_n));

  a_r7_stall_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_cs_n || !sram_cs_n) |-> stall);

  a_r7_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flash_cs_n) || $rose(sram_cs_n)) |-> !stall);
endmodule

bind wordspi_memctl wordspi_memctl_chk u_chk (.*);

// File: tb/wordspi_memctl_tb.sv
`timescale 1ns/1ps
module wordspi_memctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, miso = 1'b0;
  logic [15:0] addr = '0, wdata = '0, io_rdata = '0;
  logic [15:0] rdata, io_wdata;
  logic [7:0]  io_addr;
  logic        stall, io_stb, io_we, flash_cs_n, sram_cs_n, sclk, mosi;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wordspi_memctl u_dut (.*);

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp(string cstag, string mtag, bit e_stall, bit e_fcs, bit e_scs,
                     bit e_sclk, bit e_mosi, bit e_io);
    chk("R7", "stall", 16'(stall), 16'(e_stall));
    chk(cstag, "flash_cs_n", 16'(flash_cs_n), 16'(e_fcs));
    chk(cstag, "sram_cs_n", 16'(sram_cs_n), 16'(e_scs));
    chk("R6", "sclk", 16'(sclk), 16'(e_sclk));
    chk(mtag, "mosi", 16'(mosi), 16'(e_mosi));
    chk("R2", "io_stb", 16'(io_stb), 16'(e_io));
  endtask

  task automatic idle_cycle(string tag);
    @(posedge clk); #1;
    req = 1'b0;
    @(negedge clk);
    cmp(tag, tag, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic spi_access(bit wr, logic [15:0] a, logic [15:0] wd,
                            logic [15:0] resp_word, string rtag);
    bit          fl = (a <= 16'h7EFF);
    logic [23:0] ba = 24'(a) * 24'd2;
    logic [47:0] fr = {wr ? 8'h02 : 8'h03, ba, wr ? wd : 16'h0000};
    logic [47:0] rs = {32'hC3A5_5A3C ^ {a, wd}, resp_word};
    @(posedge clk); #1;
    req = 1'b1; we = wr; addr = a; wdata = wd; miso = 1'b0;
    @(negedge clk);
    cmp(rtag, rtag, 1, 1, 1, 0, 0, 0);
    for (int j = 1; j <= 96; j++) begin
      int b = (j - 1) / 2;
      int p = (j - 1) % 2;
      string mt = (b < 8) ? rtag : (b < 32) ? "R4" : "R5";
      @(posedge clk); #1;
      if (p == 0) miso = rs[47-b];
      @(negedge clk);
      cmp(rtag, mt, 1, !fl, fl, p[0], fr[47-b], 0);
    end
    @(posedge clk); #1;
    @(negedge clk);
    cmp("R9", "R7", 0, 1, 1, 0, 0, 0);
    if (!wr) chk("R5", "rdata", rdata, resp_word);
    idle_cycle("R9");
  endtask

  task automatic io_access(bit wr, logic [15:0] a, logic [15:0] wd,
                           logic [15:0] rv, string rtag);
    @(posedge clk); #1;
    req = 1'b1; we = wr; addr = a; wdata = wd; io_rdata = rv;
    @(negedge clk);
    cmp(rtag, "R2", 0, 1, 1, 0, 0, 1);
    chk("R2", "io_addr", 16'(io_addr), 16'(a[7:0]));
    chk("R2", "io_we", 16'(io_we), 16'(wr));
    if (wr) chk("R2", "io_wdata", io_wdata, wd);
    else    chk("R2", "rdata", rdata, rv);
    idle_cycle("R9");
  endtask

  task automatic flash_write(logic [15:0] a, logic [15:0] wd);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = wd;
    @(negedge clk);
    cmp("R8", "R8", 1, 1, 1, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      if (k > 0) req = 1'b0;
      @(negedge clk);
      cmp("R8", "R8", 0, 1, 1, 0, 0, 0);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("R9", "R9", 0, 1, 1, 0, 0, 0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R9", "R9", 0, 1, 1, 0, 0, 0);

    spi_access(1'b0, 16'h1234, 16'h0000, 16'hBEEF, "R1");
    spi_access(1'b0, 16'h7EFF, 16'h0000, 16'h8001, "R10");
    spi_access(1'b0, 16'h8000, 16'h0000, 16'h5AA5, "R10");
    spi_access(1'b1, 16'hFFFF, 16'hA55A, 16'h0000, "R3");
    spi_access(1'b1, 16'h9ABC, 16'h8001, 16'h0000, "R3");
    spi_access(1'b0, 16'hC001, 16'h0000, 16'h0000, "R3");
    spi_access(1'b0, 16'h0000, 16'h0000, 16'hFFFF, "R1");
    io_access(1'b0, 16'h7F00, 16'h0000, 16'h1357, "R10");
    io_access(1'b1, 16'h7FFF, 16'hCAFE, 16'h0000, "R10");
    io_access(1'b0, 16'h7F21, 16'h0000, 16'h00A7, "R2");
    flash_write(16'h0100, 16'hDEAD);
    flash_write(16'h7EFF, 16'h1111);
    spi_access(1'b0, 16'h4321, 16'h0000, 16'h6C93, "R1");
    idle_cycle("R9");
    done = 1;
    report();
  end
endmodule